// File: doc/BRIEF.md
# Dual-Pipeline Indexed Register Access Controller

This block is the host-side front end for the configuration registers of a display engine with two pipelines, A and B. The host sees a small strobe bus. Each register group is reached through an index port and a data port. A write to the index port selects a register in the group, and the data port then reads or writes that register. A set of direct registers is reached by address alone.

Each group keeps its index once per pipeline. A 5-bit mode register decides which copy of the index is used and whether the host may change it. For the mirrored groups, it also decides which pipeline copies receive writes. The groups fall into two classes:
- **General groups** (five by default): mode bit 4 gates index writes and mode bit 3 picks the pipeline. The upper part of the index space maps to a register array that both pipelines share.
- **Mirrored groups** (three by default): these groups ignore bits 4 and 3. Bits 1:0 form a write mask over the two pipelines, and bit 2 picks the pipeline that reads are served from.

Read data is registered. It appears on `rd_data` one cycle after the read strobe and holds until the next read.

Top module: `dpr_host_access`

## Requirements
- R1: After reset the mode register, every index, every group register, every direct register and `rd_data` are all 0.
- R2: Address 0 is the mode register. A write stores `wdata[4:0]`, and a read returns those 5 bits with bits 7:5 reading as 0.
- R3: For a general group (group g at index address 8+2g and data address 9+2g, g = 0..4), an index write while mode bit 4 is 0 leaves both pipelines' indices unchanged.
- R4: For a general group, an index write while mode bit 4 is 1 stores `wdata[5:0]` into the index of the pipeline chosen by mode bit 3 (0 = A, 1 = B). The other pipeline's index keeps its value.
- R5: A read of a general group's index port returns the index of the pipeline chosen by mode bit 3, whatever the value of bit 4.
- R6: General group data accesses use the index of the pipeline chosen by mode bit 3. Index values below 48 address that pipeline's own array. Values from 48 to 63 address one array shared by both pipelines.
- R7: For a mirrored group (group g = 5..7, same address rule), an index write goes to pipeline A's index when mode bit 0 is set and to pipeline B's index when mode bit 1 is set. When both bits are set, both indices update on the same edge. When neither is set, no index changes. Mode bits 4 and 3 have no effect.
- R8: A mirrored group data write updates, on one edge, the array of every pipeline enabled by mode bits 1:0. Each pipeline writes at its own current index.
- R9: Mirrored group reads of the index and data ports come from pipeline B when mode bit 2 is 1 and from pipeline A when it is 0.
- R10: The four direct registers at addresses 1 to 4 are read and written as plain 8-bit registers, whatever the mode register holds.
- R11: `rd_data` is loaded only in the cycle after `rd_en`. It holds its value otherwise, and reads of unmapped addresses (5 to 7 and 24 to 31) return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 5 | Port address for the access |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| rd_data | output | 8 | Registered read data, valid the cycle after `rd_en` |

## Verification
The bench goes after the pipeline-crossing cases:
- **Index write under one pipeline, read under the other.** A design that ignored the select bit, or wrote both copies, would return the freshly written index where the untouched one is expected.
- **Locked index writes.** A design that ignored the write-enable bit would show the new value on the next index read.
- **Shared-window boundary at index 48.** Indices 47 and 48 are written through different pipelines. A wrong comparison would alias the per-pipeline array into the shared one, or the other way round.

For the mirrored groups, the bench works through all four mask values with the two indices deliberately left different. A design that wrote through a single index, or treated mask 00 as "both", then returns a byte in the wrong place.

Randomised traffic also toggles the read-side select between writes, which exposes a read path that follows the write mask instead.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

   // mode register bit positions (5 stored bits)
   localparam int MODE_W      = 5;
   localparam int MB_MASK_A   = 0;
   localparam int MB_MASK_B   = 1;
   localparam int MB_RD_B     = 2;
   localparam int MB_SEL_B    = 3;
   localparam int MB_IDX_WEN  = 4;

   typedef struct packed {
      logic       idx_wen;   // general groups: index write allowed
      logic       sel_b;     // general groups: pipeline B index/array
      logic       rd_b;      // mirrored groups: reads served by B
      logic [1:0] wmask;     // mirrored groups: {B,A} write targets
   } mode_ctl_t;

   typedef enum logic [0:0] {
      GRP_GENERAL  = 1'b0,
      GRP_MIRRORED = 1'b1
   } grp_class_e;

endpackage

// File: rtl/dpr_mode_decode.sv
module dpr_mode_decode
   import dpr_pkg::*;
(
   input  logic [MODE_W-1:0] mode_q,
   output mode_ctl_t         ctl
);

   always_comb begin
      ctl.idx_wen  = mode_q[MB_IDX_WEN];
      ctl.sel_b    = mode_q[MB_SEL_B];
      ctl.rd_b     = mode_q[MB_RD_B];
      ctl.wmask[0] = mode_q[MB_MASK_A];
      ctl.wmask[1] = mode_q[MB_MASK_B];
   end

endmodule

// File: rtl/dpr_gen_group.sv
module dpr_gen_group #(
   parameter int IDX_W       = 6,
   parameter int DATA_W      = 8,
   parameter int SHARED_BASE = 48
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              idx_wr,
   input  logic              dat_wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              idx_wen,
   input  logic              sel_b,
   output logic [IDX_W-1:0]  idx_rd_o,
   output logic [DATA_W-1:0] dat_rd_o
);

   localparam int DEPTH    = 1 << IDX_W;
   localparam bit HAS_SH   = (SHARED_BASE < DEPTH);
   localparam int SH_DEPTH = HAS_SH ? (DEPTH - SHARED_BASE) : 2;
   localparam int SH_W     = $clog2(SH_DEPTH);

   if (HAS_SH && SH_DEPTH < 2) begin : g_chk_sh
      $error("dpr_gen_group: shared window needs at least two entries");
   end

   logic [1:0][IDX_W-1:0] idx_q;
   logic [DATA_W-1:0]     own_q [2][DEPTH];
   logic [IDX_W-1:0]      cur_idx;
   logic                  sh_hit;
   logic [DATA_W-1:0]     sh_rd;

   assign cur_idx = idx_q[sel_b];

   if (HAS_SH) begin : g_shared
      logic [DATA_W-1:0] sh_q [SH_DEPTH];
      logic [SH_W-1:0]   sh_off;

      assign sh_hit = (cur_idx >= IDX_W'(SHARED_BASE));
      assign sh_off = SH_W'(cur_idx - IDX_W'(SHARED_BASE));
      assign sh_rd  = sh_q[sh_off];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int i = 0; i < SH_DEPTH; i++) sh_q[i] <= '0;
         end else if (dat_wr && sh_hit) begin
            sh_q[sh_off] <= wdata;
         end
      end
   end else begin : g_no_shared
      assign sh_hit = 1'b0;
      assign sh_rd  = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q <= '0;
         for (int p = 0; p < 2; p++)
            for (int i = 0; i < DEPTH; i++) own_q[p][i] <= '0;
      end else begin
         if (idx_wr && idx_wen) idx_q[sel_b] <= wdata[IDX_W-1:0];
         if (dat_wr && !sh_hit) own_q[sel_b][cur_idx] <= wdata;
      end
   end

   assign idx_rd_o = cur_idx;
   assign dat_rd_o = sh_hit ? sh_rd : own_q[sel_b][cur_idx];

   a_r3_idx_locked : assert property (@(posedge clk) disable iff (!rst_n)
      (idx_wr && !idx_wen) |=> ($stable(idx_q[0]) && $stable(idx_q[1])));

   a_r4_b_kept : assert property (@(posedge clk) disable iff (!rst_n)
      (idx_wr && !sel_b) |=> $stable(idx_q[1]));

   a_r4_a_kept : assert property (@(posedge clk) disable iff (!rst_n)
      (idx_wr && sel_b) |=> $stable(idx_q[0]));

endmodule

// File: rtl/dpr_mirror_group.sv
module dpr_mirror_group #(
   parameter int IDX_W  = 6,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              idx_wr,
   input  logic              dat_wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [1:0]        wmask,
   input  logic              rd_b,
   output logic [IDX_W-1:0]  idx_rd_o,
   output logic [DATA_W-1:0] dat_rd_o
);

   localparam int DEPTH = 1 << IDX_W;

   logic [1:0][IDX_W-1:0]  pidx;
   logic [1:0][DATA_W-1:0] pdat;

   for (genvar p = 0; p < 2; p++) begin : g_pipe
      logic [IDX_W-1:0]  idx_q;
      logic [DATA_W-1:0] arr_q [DEPTH];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            idx_q <= '0;
            for (int i = 0; i < DEPTH; i++) arr_q[i] <= '0;
         end else begin
            if (idx_wr && wmask[p]) idx_q <= wdata[IDX_W-1:0];
            if (dat_wr && wmask[p]) arr_q[idx_q] <= wdata;
         end
      end

      assign pidx[p] = idx_q;
      assign pdat[p] = arr_q[idx_q];
   end

   assign idx_rd_o = pidx[rd_b];
   assign dat_rd_o = pdat[rd_b];

   a_r7_mask_none : assert property (@(posedge clk) disable iff (!rst_n)
      (idx_wr && wmask == 2'b00) |=> $stable(pidx));

   a_r7_a_only : assert property (@(posedge clk) disable iff (!rst_n)
      (idx_wr && wmask == 2'b01) |=> $stable(pidx[1]));

   a_r7_both_equal : assert property (@(posedge clk) disable iff (!rst_n)
      (idx_wr && wmask == 2'b11) |=> (pidx[0] == pidx[1]));

   a_r8_idx_untouched : assert property (@(posedge clk) disable iff (!rst_n)
      (dat_wr && !idx_wr) |=> $stable(pidx));

endmodule

// File: rtl/dpr_host_access.sv
module dpr_host_access
   import dpr_pkg::*;
#(
   parameter int ADDR_W      = 5,
   parameter int DATA_W      = 8,
   parameter int IDX_W       = 6,
   parameter int NUM_GEN     = 5,
   parameter int NUM_MIR     = 3,
   parameter int NUM_DIRECT  = 4,
   parameter int SHARED_BASE = 48
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              wr_en,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data
);

   localparam int NUM_GRP  = NUM_GEN + NUM_MIR;
   localparam int GRP_BASE = 1 << $clog2(NUM_DIRECT + 1);
   localparam int GRP_END  = GRP_BASE + 2 * NUM_GRP;
   localparam logic [ADDR_W-1:0] GRP_BASE_A = ADDR_W'(GRP_BASE);
   localparam logic [ADDR_W-1:0] GRP_END_A  = ADDR_W'(GRP_END);

   if (GRP_END > (1 << ADDR_W)) begin : g_chk_addr
      $error("dpr_host_access: address space too small for the groups");
   end
   if (IDX_W > DATA_W) begin : g_chk_idx
      $error("dpr_host_access: index wider than data path");
   end
   if (DATA_W < MODE_W) begin : g_chk_mode
      $error("dpr_host_access: data path narrower than mode register");
   end
   if (NUM_GRP < 1) begin : g_chk_grp
      $error("dpr_host_access: at least one register group required");
   end

   // ---------------- mode register and decode ----------------
   logic [MODE_W-1:0] mode_q;
   mode_ctl_t         ctl;

   always_ff @(posedge clk) begin
      if (!rst_n)                          mode_q <= '0;
      else if (wr_en && addr == '0)        mode_q <= wdata[MODE_W-1:0];
   end

   dpr_mode_decode i_mode_decode (
      .mode_q (mode_q),
      .ctl    (ctl)
   );

   // ---------------- direct registers ----------------
   logic [DATA_W-1:0] dir_q [NUM_DIRECT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_DIRECT; i++) dir_q[i] <= '0;
      end else if (wr_en) begin
         for (int i = 0; i < NUM_DIRECT; i++)
            if (addr == ADDR_W'(i + 1)) dir_q[i] <= wdata;
      end
   end

   // ---------------- group decode ----------------
   logic                       in_grp;
   logic [ADDR_W-1:0]          grp_off;
   logic [ADDR_W-2:0]          grp_sel;
   logic                       is_dat;
   logic [NUM_GRP-1:0][IDX_W-1:0]  grp_idx_rd;
   logic [NUM_GRP-1:0][DATA_W-1:0] grp_dat_rd;

   assign in_grp  = (addr >= GRP_BASE_A) && (addr < GRP_END_A);
   assign grp_off = addr - GRP_BASE_A;
   assign grp_sel = grp_off[ADDR_W-1:1];
   assign is_dat  = grp_off[0];

   for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      localparam grp_class_e CLS = (g < NUM_GEN) ? GRP_GENERAL : GRP_MIRRORED;
      logic hit, idx_wr, dat_wr;

      assign hit    = in_grp && (grp_sel == (ADDR_W-1)'(g));
      assign idx_wr = wr_en && hit && !is_dat;
      assign dat_wr = wr_en && hit &&  is_dat;

      if (CLS == GRP_GENERAL) begin : g_general
         dpr_gen_group #(
            .IDX_W       (IDX_W),
            .DATA_W      (DATA_W),
            .SHARED_BASE (SHARED_BASE)
         ) i_group (
            .clk      (clk),
            .rst_n    (rst_n),
            .idx_wr   (idx_wr),
            .dat_wr   (dat_wr),
            .wdata    (wdata),
            .idx_wen  (ctl.idx_wen),
            .sel_b    (ctl.sel_b),
            .idx_rd_o (grp_idx_rd[g]),
            .dat_rd_o (grp_dat_rd[g])
         );
      end else begin : g_mirrored
         dpr_mirror_group #(
            .IDX_W  (IDX_W),
            .DATA_W (DATA_W)
         ) i_group (
            .clk      (clk),
            .rst_n    (rst_n),
            .idx_wr   (idx_wr),
            .dat_wr   (dat_wr),
            .wdata    (wdata),
            .wmask    (ctl.wmask),
            .rd_b     (ctl.rd_b),
            .idx_rd_o (grp_idx_rd[g]),
            .dat_rd_o (grp_dat_rd[g])
         );
      end
   end

   // ---------------- read path ----------------
   logic [DATA_W-1:0] rd_mux;

   always_comb begin
      rd_mux = '0;
      if (addr == '0) rd_mux = DATA_W'(mode_q);
      for (int i = 0; i < NUM_DIRECT; i++)
         if (addr == ADDR_W'(i + 1)) rd_mux = dir_q[i];
      for (int g = 0; g < NUM_GRP; g++)
         if (in_grp && grp_sel == (ADDR_W-1)'(g))
            rd_mux = is_dat ? grp_dat_rd[g] : DATA_W'(grp_idx_rd[g]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      rd_data <= '0;
      else if (rd_en)  rd_data <= rd_mux;
   end

   a_r11_rdata_holds : assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data));

   a_r10_direct_keeps_mode : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr != '0) |=> $stable(mode_q));

   a_r2_mode_loaded : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == '0) |=> (mode_q == $past(wdata[MODE_W-1:0])));

endmodule

// File: tb/test_dpr_host_access.sv
module test_dpr_host_access;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] addr = '0;
   logic [7:0] wdata = '0;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic [7:0] rd_data;

   always #5 clk = ~clk;

   dpr_host_access i_dpr_host_access (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr    (addr),
      .wdata   (wdata),
      .wr_en   (wr_en),
      .rd_en   (rd_en),
      .rd_data (rd_data)
   );

   // ---------------- behavioural reference ----------------
   int mode;
   int dreg [4];
   int gidx [5][2];
   int garr [5][2][64];
   int gsh  [5][16];
   int midx [3][2];
   int marr [3][2][64];
   int exp_rd;
   int total = 0;
   int bad   = 0;

   task automatic model_reset();
      mode = 0; exp_rd = 0;
      for (int i = 0; i < 4; i++) dreg[i] = 0;
      for (int g = 0; g < 5; g++)
         for (int p = 0; p < 2; p++) begin
            gidx[g][p] = 0;
            for (int i = 0; i < 64; i++) garr[g][p][i] = 0;
         end
      for (int g = 0; g < 5; g++)
         for (int i = 0; i < 16; i++) gsh[g][i] = 0;
      for (int m = 0; m < 3; m++)
         for (int p = 0; p < 2; p++) begin
            midx[m][p] = 0;
            for (int i = 0; i < 64; i++) marr[m][p][i] = 0;
         end
   endtask

   function automatic int model_read(int a);
      int g, sb, ix, p;
      if (a == 0) return mode;
      if (a >= 1 && a <= 4) return dreg[a-1];
      if (a >= 8 && a < 24) begin
         g = (a - 8) / 2;
         if (g < 5) begin
            sb = (mode >> 3) & 1;
            ix = gidx[g][sb];
            if (a % 2 == 0) return ix;
            return (ix >= 48) ? gsh[g][ix-48] : garr[g][sb][ix];
         end
         p = (mode >> 2) & 1;
         if (a % 2 == 0) return midx[g-5][p];
         return marr[g-5][p][midx[g-5][p]];
      end
      return 0;
   endfunction

   task automatic model_write(int a, int d);
      int g, sb, ix;
      if (a == 0) mode = d & 31;
      else if (a >= 1 && a <= 4) dreg[a-1] = d;
      else if (a >= 8 && a < 24) begin
         g = (a - 8) / 2;
         if (g < 5) begin
            sb = (mode >> 3) & 1;
            if (a % 2 == 0) begin
               if (((mode >> 4) & 1) == 1) gidx[g][sb] = d & 63;
            end else begin
               ix = gidx[g][sb];
               if (ix >= 48) gsh[g][ix-48] = d;
               else garr[g][sb][ix] = d;
            end
         end else begin
            for (int p = 0; p < 2; p++)
               if (((mode >> p) & 1) == 1) begin
                  if (a % 2 == 0) midx[g-5][p] = d & 63;
                  else marr[g-5][p][midx[g-5][p]] = d;
               end
         end
      end
   endtask

   // one bus cycle; rd_data compared against the model every clock
   task automatic op(input bit w, input bit r, input int a, input int d, input string req);
      int rv;
      addr = 5'(a); wdata = 8'(d); wr_en = w; rd_en = r;
      @(posedge clk);
      rv = model_read(a);
      if (r) exp_rd = rv;
      if (w) model_write(a, d);
      @(negedge clk);
      total++;
      if (rd_data !== 8'(exp_rd)) begin
         bad++;
         $display("FAIL %s addr=%0d actual=%0h expected=%0h", req, a, rd_data, exp_rd);
      end
      wr_en = 1'b0; rd_en = 1'b0;
   endtask

   task automatic wr(input int a, input int d, input string req);
      op(1'b1, 1'b0, a, d, req);
   endtask

   task automatic rd(input int a, input string req);
      op(1'b0, 1'b1, a, 0, req);
   endtask

   initial begin
      #2_000_000;
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      total++;
      if (rd_data !== 8'h00) begin
         bad++;
         $display("FAIL R1 rd_data after reset actual=%0h expected=0", rd_data);
      end
      // R1: reset contents
      rd(0, "R1"); rd(1, "R1"); rd(8, "R1"); rd(9, "R1"); rd(18, "R1"); rd(19, "R1");
      // R11: unmapped and hold
      wr(2, 8'h5A, "R10"); rd(5, "R11"); rd(26, "R11");
      rd(2, "R10"); wr(3, 8'h33, "R11"); op(1'b0, 1'b0, 2, 0, "R11");
      // R2
      wr(0, 8'hFF, "R2"); rd(0, "R2");
      // R3: locked index writes
      wr(0, 8'h00, "R3"); wr(8, 8'h15, "R3"); rd(8, "R3");
      wr(0, 8'h08, "R3"); rd(8, "R3");
      // R4/R5: write A, read under B and A
      wr(0, 8'h10, "R4"); wr(10, 8'h05, "R4"); rd(10, "R4");
      wr(0, 8'h08, "R5"); rd(10, "R5");
      wr(0, 8'h18, "R4"); wr(10, 8'h07, "R4"); rd(10, "R4");
      wr(0, 8'h10, "R5"); rd(10, "R5"); wr(0, 8'h00, "R5"); rd(10, "R5");
      // R6: per-pipe vs shared at boundary 47/48
      wr(0, 8'h10, "R6"); wr(12, 47, "R6"); wr(13, 8'hA1, "R6");
      wr(0, 8'h18, "R6"); wr(12, 47, "R6"); rd(13, "R6");
      wr(13, 8'hB2, "R6"); wr(12, 48, "R6"); wr(13, 8'hC3, "R6");
      wr(0, 8'h10, "R6"); rd(13, "R6"); wr(12, 48, "R6"); rd(13, "R6");
      wr(12, 47, "R6"); rd(13, "R6");
      // R7/R8/R9: mirrored group 5 (addr 18/19), bits 4,3 set to show no effect
      wr(0, 8'h19, "R7"); wr(18, 3, "R7"); wr(19, 8'h11, "R8");
      wr(0, 8'h1A, "R7"); wr(18, 9, "R7"); wr(19, 8'h22, "R8");
      wr(0, 8'h1B, "R8"); wr(19, 8'h44, "R8");
      rd(18, "R9"); rd(19, "R9");
      wr(0, 8'h1F, "R9"); rd(18, "R9"); rd(19, "R9");
      wr(0, 8'h04, "R7"); wr(18, 20, "R7"); rd(18, "R7");
      wr(0, 8'h00, "R7"); rd(18, "R7"); rd(19, "R9");
      wr(0, 8'h07, "R7"); wr(20, 33, "R7"); rd(20, "R7");
      wr(0, 8'h03, "R7"); rd(20, "R7");
      // R10 under various modes
      wr(0, 8'h1F, "R10"); wr(4, 8'hE7, "R10"); rd(4, "R10");
      wr(0, 8'h00, "R10"); rd(4, "R10"); rd(2, "R10");
      // mixed traffic
      for (int i = 0; i < 600; i++) begin
         int a, d, k;
         k = int'($urandom_range(0, 9));
         a = (k == 0) ? 0 : int'($urandom_range(0, 31));
         d = int'($urandom_range(0, 255));
         if (a >= 8 && (a % 2 == 0) && $urandom_range(0, 3) != 0) d = d & 8'h3F;
         if (a >= 8 && (a % 2 == 0) && $urandom_range(0, 2) == 0) d = 44 + (d & 7);
         if ($urandom_range(0, 1) == 1) wr(a, d, "R6/R8 mix");
         else rd(a, "R5/R9 mix");
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule